// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides which of several DMA channels may use a single shared bus for the next data item. Each channel raises a request and supplies a two-bit priority level. The arbiter answers with a registered one-hot grant. The grant stays on that channel until the channel pulses `done` to mark the end of its item. The arbiter then makes a fresh decision.

A mode input selects between two policies. In fixed-priority mode the highest level wins, and a tie goes to the lowest channel index. In round-robin mode the levels are ignored, and the grant rotates among the requesting channels. The rotation starts just after the channel granted last.

Decisions happen only when the bus is free or when the granted channel signals the end of its item. As a result, a more urgent request can take over only at an item boundary.

Top module: `dma_bus_arbiter`

## Requirements
- R1: `grant` is always zero-hot or one-hot. When a decision is made with no request asserted, `grant` becomes zero.
- R2: In fixed mode (`rr_mode`=0), the requesting channel with the highest level wins. Channel i's level sits in `prio[2i+1:2i]`: 3 is very high, 2 high, 1 medium, 0 low.
- R3: In fixed mode, when several requesting channels share the top level, the lowest-numbered one wins.
- R4: Once granted, a channel keeps `grant` until its own `done` bit is high at a clock edge. A `done` from any other channel has no effect.
- R5: In round-robin mode (`rr_mode`=1), levels are ignored. The search starts at the channel after the last one granted and wraps from N-1 to 0.
- R6: A higher-priority request that arrives during a held grant wins only at the next decision, which follows the granted channel's `done`.
- R7: A decision is made on any clock edge where `grant` is zero or the granted channel's `done` is high. Its result appears on `grant` after that edge, which gives one cycle of latency.
- R8: Changes to `prio` or `rr_mode` while a grant is held do not affect the current grant. They are used at the next decision.
- R9: After reset, `grant` is zero and the round-robin search starts at channel 0.
- R10: A channel that pulses `done` while still requesting takes part in the following decision and may win again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| req | input | NUM_CH | Per-channel request |
| prio | input | 2*NUM_CH | Per-channel level, two bits per channel |
| done | input | NUM_CH | Per-channel end-of-item pulse |
| grant | output | NUM_CH | Registered one-hot bus grant |

## Verification
If the internal hold logic is wrong, the grant moves while an item is still in progress. This shows up one cycle after a foreign `done` or after a new high-level request. A wrong round-robin pointer gives the wrong channel at the very next decision after a `done`. The directed sequences therefore check `grant` one cycle after every decision edge, and they also check it across cycles in which it must stay frozen.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 2
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic [NUM_CH-1:0]        win
);
  logic [PRIO_W-1:0] lvl [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lvl
      assign lvl[g] = prio[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  logic [PRIO_W-1:0] best;
  logic              found;

  // strictly-greater compare keeps the lowest index on ties
  always_comb begin
    win   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!found || lvl[i] > best)) begin
        win    = '0;
        win[i] = 1'b1;
        best   = lvl[i];
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  last,
  output logic [NUM_CH-1:0] win
);
  logic found;

  // search last+1, last+2, ... wrapping, last itself examined at the end
  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int j;
      j = int'(last) + k;
      if (j >= NUM_CH) j = j - NUM_CH;
      if (!found && req[j]) begin
        win[j] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rr_mode,
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  input  logic [NUM_CH-1:0]        done,
  output logic [NUM_CH-1:0]        grant
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] grant_q, fix_win, rr_win, pick;
  logic [IDX_W-1:0]  last_q, pick_idx;
  logic              decide;
  arb_mode_e         cur_mode;

  arb_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
    .req (req),
    .prio(prio),
    .win (fix_win)
  );

  arb_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rr (
    .req (req),
    .last(last_q),
    .win (rr_win)
  );

  assign cur_mode = arb_mode_e'(rr_mode);
  assign decide   = (grant_q == '0) || ((grant_q & done) != '0);
  assign pick     = (cur_mode == ARB_ROUND) ? rr_win : fix_win;

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (pick[i]) pick_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= IDX_W'(NUM_CH - 1);
    end else if (decide) begin
      grant_q <= pick;
      if (pick != '0) last_q <= pick_idx;
    end
  end

  assign grant = grant_q;

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && req == '0) |=> grant == '0);

  // R4
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & done) == '0) |=> $stable(grant));

  // R7
  decide_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && req != '0) |=> (grant != '0 && (grant & ~$past(req)) == '0));
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rr_mode = 1'b0;
  logic [N-1:0] req = '0;
  logic [2*N-1:0] prio = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] grant;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_bus_arbiter #(.NUM_CH(N), .PRIO_W(2)) dut (
    .clk(clk), .rst(rst), .rr_mode(rr_mode), .req(req),
    .prio(prio), .done(done), .grant(grant)
  );

  task automatic check(input logic [N-1:0] exp, input string tag);
    checks++;
    if (grant !== exp) begin
      failures++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic set_lvl(input int ch, input logic [1:0] lvl);
    prio[ch*2 +: 2] = lvl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; done = '0; prio = '0; rr_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // pulse done on channel ch, with req changed to new_req in the same cycle
  task automatic pulse_done(input int ch, input logic [N-1:0] new_req);
    @(negedge clk);
    done = '0; done[ch] = 1'b1; req = new_req;
    @(negedge clk);
    done = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check('0, "R9 reset");
    @(negedge clk);
    check('0, "R1 idle");
  endtask

  task automatic t_fixed();
    do_reset();
    set_lvl(1, 2'd1); set_lvl(5, 2'd3); set_lvl(2, 2'd2);
    req = 8'b0010_0110;
    #1 check('0, "R7 before edge");
    @(negedge clk);
    check(8'b0010_0000, "R2 highest level");
    pulse_done(5, '0);
    check('0, "R1 no request");
  endtask

  task automatic t_tie();
    do_reset();
    set_lvl(3, 2'd2); set_lvl(6, 2'd2); set_lvl(1, 2'd1);
    req = 8'b0100_1010;
    @(negedge clk);
    check(8'b0000_1000, "R3 tie lowest index");
    pulse_done(3, 8'b0100_0010);
    check(8'b0100_0000, "R3 next");
    pulse_done(6, '0);
  endtask

  task automatic t_hold();
    do_reset();
    set_lvl(3, 2'd0);
    req = 8'b0000_1000;
    @(negedge clk);
    check(8'b0000_1000, "R4 granted");
    set_lvl(0, 2'd3);
    req = 8'b0000_1001;
    @(negedge clk);
    check(8'b0000_1000, "R6 no preempt");
    done = 8'b0000_0001;
    @(negedge clk);
    done = '0;
    check(8'b0000_1000, "R4 foreign done");
    pulse_done(3, 8'b0000_1001);
    check(8'b0000_0001, "R6 boundary preempt");
    pulse_done(0, '0);
  endtask

  task automatic t_prio_change();
    do_reset();
    set_lvl(2, 2'd0); set_lvl(5, 2'd1);
    req = 8'b0010_0100;
    @(negedge clk);
    check(8'b0010_0000, "R8 initial");
    set_lvl(2, 2'd3);
    @(negedge clk);
    check(8'b0010_0000, "R8 held after prio change");
    pulse_done(5, 8'b0010_0100);
    check(8'b0000_0100, "R8 new prio used");
    pulse_done(2, '0);
  endtask

  task automatic t_regain();
    do_reset();
    set_lvl(0, 2'd3); set_lvl(4, 2'd0);
    req = 8'b0001_0001;
    @(negedge clk);
    check(8'b0000_0001, "R10 first");
    pulse_done(0, 8'b0001_0001);
    check(8'b0000_0001, "R10 regain");
    pulse_done(0, '0);
  endtask

  task automatic t_round();
    do_reset();
    rr_mode = 1'b1;
    set_lvl(6, 2'd3);
    req = 8'b0101_0010;
    @(negedge clk);
    check(8'b0000_0010, "R5 first from ch0");
    pulse_done(1, 8'b0101_0010);
    check(8'b0001_0000, "R5 ch4");
    pulse_done(4, 8'b0101_0010);
    check(8'b0100_0000, "R5 ch6");
    pulse_done(6, 8'b0101_0010);
    check(8'b0000_0010, "R5 wrap");
    rr_mode = 1'b0;
    @(negedge clk);
    check(8'b0000_0010, "R8 mode change held");
    pulse_done(1, 8'b0101_0010);
    check(8'b0100_0000, "R8 fixed after mode change");
    pulse_done(6, '0);
    check('0, "R1 drained");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_tie();
    t_hold();
    t_prio_change();
    t_regain();
    t_round();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule